// File: doc/BRIEF.md
# Chained Descriptor DMA Source Walker

The walker feeds a hash core with source data read from memory. In chained mode it follows a list of four-word descriptors kept in memory. Each descriptor names a data region and the location of the next descriptor. In direct mode it streams one region whose start address and byte count come from input ports. The data arrives as 32-bit words on a valid/ready stream. Each word carries a byte-count qualifier, and the word that ends the whole transfer is marked.

Memory is reached through a simple read port. The walker issues one request, with an address and a beat count, and then accepts that many in-order response words before it issues another. The walker reads a descriptor with one four-beat request. It fetches the data region in bursts of at most `MAX_BURST` words. Then it either follows the next pointer or stops, depending on the terminate flag in the descriptor. A one-cycle source-done pulse reports that all data has been handed over; the hash core downstream may still be working at that moment. If a descriptor pointer is not 16-byte aligned, the walker stops, pulses an error and never fetches from that pointer.

Top module: `lldma_walker`

## Requirements
- R1: Out of reset the walker is idle: `busy`, `rd_req_valid`, `out_valid`, `src_done` and `desc_err` are all low.
- R2: In direct mode (`linked_mode`=0) a `start` pulse streams ceil(`direct_len`/4) words read from consecutive word addresses beginning at `direct_addr` (word aligned), in ascending address order.
- R3: Every data read request asks for between 1 and `MAX_BURST` beats. Consecutive data requests of one region cover consecutive addresses. A request keeps its address and beat count until `rd_req_ready` accepts it.
- R4: In chained mode each descriptor is fetched with a single 4-beat request at a 16-byte aligned address. Its words are read as: word 0 source address, word 1 byte length, word 2 next descriptor pointer, word 3 flags.
- R5: When bit 31 of the flags word is 1, the chain ends after that descriptor and its next pointer is never fetched. When bit 31 is 0, the walker fetches the next pointer. The data of all descriptors is streamed back to back in chain order.
- R6: `out_bytes` holds the number of valid bytes in the word, from 1 to 4. It is 4 on every word except the last word of a region whose length mod 4 is nonzero; on that word it equals length mod 4.
- R7: `out_last` is high only on the final word of the final region (the direct region, or the region of the terminating descriptor).
- R8: `src_done` is a single-cycle pulse. It is high in the second cycle after the final word is accepted on the output, and `busy` is low in the following cycle.
- R9: A first or next descriptor pointer with nonzero bits [3:0] is not fetched. The walker raises `desc_err` for one cycle, raises no `src_done`, and returns to idle. Words already streamed are kept.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold, and no word is lost or repeated.
- R11: A `start` pulse while `busy` is high is ignored.
- R12: A direct transfer with `direct_len`=0 streams no words and still pulses `src_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that launches a transfer when idle |
| linked_mode | input | 1 | 1: follow a descriptor chain, 0: direct region |
| first_desc_ptr | input | 32 | Address of the first descriptor (chained mode) |
| direct_addr | input | 32 | Region start address (direct mode) |
| direct_len | input | 32 | Region length in bytes (direct mode) |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Byte address of the first beat |
| rd_req_beats | output | BEAT_W | Number of 32-bit beats requested |
| rd_rsp_valid | input | 1 | Response word valid |
| rd_rsp_ready | output | 1 | Walker accepts the response word |
| rd_rsp_data | input | 32 | Response word |
| out_valid | output | 1 | Data word valid toward the hash core |
| out_ready | input | 1 | Hash core accepts the word |
| out_data | output | 32 | Data word |
| out_bytes | output | 3 | Valid bytes in the word, 1 to 4 |
| out_last | output | 1 | Final word of the whole transfer |
| busy | output | 1 | Transfer in progress |
| src_done | output | 1 | Pulse: all source data delivered |
| desc_err | output | 1 | Pulse: misaligned descriptor pointer |

## Verification
The assertions watch some properties on every cycle: descriptor requests are aligned and never overlap data requests, burst sizes stay within range, a pending request holds steady, the byte qualifier stays in range, the done and error pulses are exclusive, and the port is silent when idle. Other behaviour only the bench's scenarios can show. That covers the content and order of the streamed words across a chain, the terminate flag stopping the chain, an unfetched bad pointer, the exact cycle of the done pulse, a start ignored while busy, and a zero-length region.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int WORD_W      = 32;
  localparam int DESC_WORDS  = 4;
  localparam int ALIGN_BITS  = 4;
  localparam int TERM_BIT    = 31;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH_DESC,
    W_FETCH_DATA,
    W_NEXT,
    W_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    E_IDLE,
    E_REQ,
    E_RSP
  } eng_state_e;
endpackage

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              linked,
  input  logic [WORD_W-1:0] first_ptr,
  input  logic [WORD_W-1:0] dir_addr,
  input  logic [WORD_W-1:0] dir_len,
  output logic              desc_req_valid,
  input  logic              desc_req_ready,
  output logic [WORD_W-1:0] desc_req_addr,
  input  logic              desc_rsp_valid,
  output logic              desc_rsp_ready,
  input  logic [WORD_W-1:0] desc_rsp_data,
  output logic              seg_start,
  output logic [WORD_W-1:0] seg_addr,
  output logic [WORD_W-1:0] seg_len,
  output logic              seg_final,
  input  logic              seg_done,
  output logic              busy,
  output logic              src_done,
  output logic              desc_err
);
  walk_state_e       state_q, state_d;
  logic [WORD_W-1:0] ptr_q, ptr_d;
  logic [WORD_W-1:0] nxt_q, nxt_d;
  logic [WORD_W-1:0] sa_q, sa_d;
  logic [WORD_W-1:0] sl_q, sl_d;
  logic              fin_q, fin_d;
  logic              sent_q, sent_d;
  logic [1:0]        widx_q, widx_d;
  logic              launch_q, launch_d;
  logic              err_q, err_d;

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    nxt_d    = nxt_q;
    sa_d     = sa_q;
    sl_d     = sl_q;
    fin_d    = fin_q;
    sent_d   = sent_q;
    widx_d   = widx_q;
    launch_d = 1'b0;
    err_d    = 1'b0;
    case (state_q)
      W_IDLE: begin
        if (start) begin
          if (linked) begin
            if (first_ptr[ALIGN_BITS-1:0] != '0) begin
              err_d = 1'b1;
            end else begin
              ptr_d   = first_ptr;
              sent_d  = 1'b0;
              widx_d  = '0;
              state_d = W_FETCH_DESC;
            end
          end else begin
            sa_d     = dir_addr;
            sl_d     = dir_len;
            fin_d    = 1'b1;
            launch_d = 1'b1;
            state_d  = W_FETCH_DATA;
          end
        end
      end
      W_FETCH_DESC: begin
        if (!sent_q && desc_req_ready) sent_d = 1'b1;
        if (sent_q && desc_rsp_valid) begin
          widx_d = widx_q + 2'd1;
          case (widx_q)
            2'd0: sa_d = desc_rsp_data;
            2'd1: sl_d = desc_rsp_data;
            2'd2: nxt_d = desc_rsp_data;
            default: begin
              fin_d    = desc_rsp_data[TERM_BIT];
              launch_d = 1'b1;
              state_d  = W_FETCH_DATA;
            end
          endcase
        end
      end
      W_FETCH_DATA: begin
        if (seg_done) state_d = fin_q ? W_DONE : W_NEXT;
      end
      W_NEXT: begin
        if (nxt_q[ALIGN_BITS-1:0] != '0) begin
          err_d   = 1'b1;
          state_d = W_IDLE;
        end else begin
          ptr_d   = nxt_q;
          sent_d  = 1'b0;
          widx_d  = '0;
          state_d = W_FETCH_DESC;
        end
      end
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= W_IDLE;
      ptr_q    <= '0;
      nxt_q    <= '0;
      sa_q     <= '0;
      sl_q     <= '0;
      fin_q    <= 1'b0;
      sent_q   <= 1'b0;
      widx_q   <= '0;
      launch_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      nxt_q    <= nxt_d;
      sa_q     <= sa_d;
      sl_q     <= sl_d;
      fin_q    <= fin_d;
      sent_q   <= sent_d;
      widx_q   <= widx_d;
      launch_q <= launch_d;
      err_q    <= err_d;
    end
  end

  assign desc_req_valid = (state_q == W_FETCH_DESC) && !sent_q;
  assign desc_req_addr  = ptr_q;
  assign desc_rsp_ready = (state_q == W_FETCH_DESC) && sent_q;
  assign seg_start      = launch_q;
  assign seg_addr       = sa_q;
  assign seg_len        = sl_q;
  assign seg_final      = fin_q;
  assign busy           = (state_q != W_IDLE);
  assign src_done       = (state_q == W_DONE);
  assign desc_err       = err_q;

  // R4: descriptor fetches only go to aligned pointers
  assert_desc_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req_valid |-> (desc_req_addr[ALIGN_BITS-1:0] == '0));
  // R9: error and completion never coincide
  assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_done && desc_err));
  // R9: an error leaves the walker idle
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> !busy);
  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_done |=> !src_done);
endmodule

// File: rtl/lldma_seg_engine.sv
module lldma_seg_engine
  import lldma_pkg::*;
#(
  parameter int MAX_BURST = 8,
  parameter int BEAT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_start,
  input  logic [WORD_W-1:0] seg_addr,
  input  logic [WORD_W-1:0] seg_len,
  input  logic              seg_final,
  output logic              seg_done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [WORD_W-1:0] req_addr,
  output logic [BEAT_W-1:0] req_beats,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [2:0]        out_bytes,
  output logic              out_last
);
  localparam int WCNT_W = WORD_W - 1;
  localparam logic [WCNT_W-1:0] MAXB_W = WCNT_W'(MAX_BURST);

  eng_state_e        st_q, st_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [WCNT_W-1:0] req_left_q, req_left_d;
  logic [WCNT_W-1:0] all_left_q, all_left_d;
  logic [BEAT_W-1:0] blt_q, blt_d;
  logic [1:0]        tail_q, tail_d;
  logic              fin_q, fin_d;
  logic              done_q, done_d;
  logic [WORD_W:0]   len_sum;
  logic [WCNT_W-1:0] words;
  logic [BEAT_W-1:0] burst;
  logic              take;

  assign len_sum = {1'b0, seg_len} + (WORD_W+1)'(3);
  assign words   = len_sum[WORD_W:2];
  assign burst   = (req_left_q > MAXB_W) ? BEAT_W'(MAX_BURST) : req_left_q[BEAT_W-1:0];
  assign take    = (st_q == E_RSP) && rsp_valid && out_ready;

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    req_left_d = req_left_q;
    all_left_d = all_left_q;
    blt_d      = blt_q;
    tail_d     = tail_q;
    fin_d      = fin_q;
    done_d     = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (seg_start) begin
          addr_d = seg_addr;
          tail_d = seg_len[1:0];
          fin_d  = seg_final;
          if (words == '0) begin
            done_d = 1'b1;
          end else begin
            req_left_d = words;
            all_left_d = words;
            st_d       = E_REQ;
          end
        end
      end
      E_REQ: begin
        if (req_ready) begin
          addr_d     = addr_q + (WORD_W'(burst) << 2);
          req_left_d = req_left_q - WCNT_W'(burst);
          blt_d      = burst;
          st_d       = E_RSP;
        end
      end
      default: begin
        if (take) begin
          blt_d      = blt_q - BEAT_W'(1);
          all_left_d = all_left_q - WCNT_W'(1);
          if (blt_q == BEAT_W'(1)) begin
            if (req_left_q == '0) begin
              done_d = 1'b1;
              st_d   = E_IDLE;
            end else begin
              st_d   = E_REQ;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= E_IDLE;
      addr_q     <= '0;
      req_left_q <= '0;
      all_left_q <= '0;
      blt_q      <= '0;
      tail_q     <= '0;
      fin_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      addr_q     <= addr_d;
      req_left_q <= req_left_d;
      all_left_q <= all_left_d;
      blt_q      <= blt_d;
      tail_q     <= tail_d;
      fin_q      <= fin_d;
      done_q     <= done_d;
    end
  end

  assign req_valid = (st_q == E_REQ);
  assign req_addr  = addr_q;
  assign req_beats = burst;
  assign rsp_ready = (st_q == E_RSP) && out_ready;
  assign out_valid = (st_q == E_RSP) && rsp_valid;
  assign out_data  = rsp_data;
  assign out_bytes = ((all_left_q == WCNT_W'(1)) && (tail_q != 2'd0)) ? {1'b0, tail_q} : 3'd4;
  assign out_last  = (st_q == E_RSP) && (all_left_q == WCNT_W'(1)) && fin_q;
  assign seg_done  = done_q;

  // R3: burst size within range
  assert_burst_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != '0) && (req_beats <= BEAT_W'(MAX_BURST)));
  // R3: a pending request holds steady
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_beats));
  // R6: byte qualifier stays between 1 and 4
  assert_bytes_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bytes >= 3'd1) && (out_bytes <= 3'd4));
  // R7: accepting the final word ends the region
  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> seg_done);
endmodule

// File: rtl/lldma_walker.sv
module lldma_walker
  import lldma_pkg::*;
#(
  parameter int MAX_BURST = 8,
  localparam int BEAT_W = $clog2(((MAX_BURST > DESC_WORDS) ? MAX_BURST : DESC_WORDS) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              linked_mode,
  input  logic [31:0]       first_desc_ptr,
  input  logic [31:0]       direct_addr,
  input  logic [31:0]       direct_len,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [31:0]       rd_req_addr,
  output logic [BEAT_W-1:0] rd_req_beats,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [31:0]       rd_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic [2:0]        out_bytes,
  output logic              out_last,
  output logic              busy,
  output logic              src_done,
  output logic              desc_err
);
  localparam logic [BEAT_W-1:0] DESC_BEATS = BEAT_W'(DESC_WORDS);

  logic              d_req_valid, d_rsp_ready;
  logic [WORD_W-1:0] d_req_addr;
  logic              e_req_valid, e_rsp_ready;
  logic [WORD_W-1:0] e_req_addr;
  logic [BEAT_W-1:0] e_req_beats;
  logic              seg_start, seg_final, seg_done;
  logic [WORD_W-1:0] seg_addr, seg_len;

  lldma_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .linked         (linked_mode),
    .first_ptr      (first_desc_ptr),
    .dir_addr       (direct_addr),
    .dir_len        (direct_len),
    .desc_req_valid (d_req_valid),
    .desc_req_ready (rd_req_ready),
    .desc_req_addr  (d_req_addr),
    .desc_rsp_valid (rd_rsp_valid),
    .desc_rsp_ready (d_rsp_ready),
    .desc_rsp_data  (rd_rsp_data),
    .seg_start      (seg_start),
    .seg_addr       (seg_addr),
    .seg_len        (seg_len),
    .seg_final      (seg_final),
    .seg_done       (seg_done),
    .busy           (busy),
    .src_done       (src_done),
    .desc_err       (desc_err)
  );

  lldma_seg_engine #(
    .MAX_BURST (MAX_BURST),
    .BEAT_W    (BEAT_W)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_start (seg_start),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .seg_final (seg_final),
    .seg_done  (seg_done),
    .req_valid (e_req_valid),
    .req_ready (rd_req_ready),
    .req_addr  (e_req_addr),
    .req_beats (e_req_beats),
    .rsp_valid (rd_rsp_valid),
    .rsp_ready (e_rsp_ready),
    .rsp_data  (rd_rsp_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_bytes (out_bytes),
    .out_last  (out_last)
  );

  assign rd_req_valid = d_req_valid | e_req_valid;
  assign rd_req_addr  = d_req_valid ? d_req_addr : e_req_addr;
  assign rd_req_beats = d_req_valid ? DESC_BEATS : e_req_beats;
  assign rd_rsp_ready = d_rsp_ready | e_rsp_ready;

  // R4: descriptor and data requests never share the port
  assert_port_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_req_valid && e_req_valid));
  // R1: an idle walker is silent on both ports
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !out_valid);
endmodule

// File: tb/tb_lldma_walker.sv
module tb_lldma_walker;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 8;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, linked_mode = 1'b0;
  logic [31:0] first_desc_ptr = '0, direct_addr = '0, direct_len = '0;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic [BW-1:0] rd_req_beats;
  logic out_valid, out_ready, out_last, busy, src_done, desc_err;
  logic [31:0] out_data;
  logic [2:0] out_bytes;

  always #(CLK_PERIOD/2) clk = ~clk;

  lldma_walker #(.MAX_BURST(MAXB)) dut (.*);

  int checks = 0, errors = 0;
  logic [31:0] mem [0:255];
  logic pend;
  logic [31:0] paddr;
  logic [BW-1:0] pcnt;
  bit bp_mode = 0, rq_stall = 0;
  int cyc = 0;

  assign rd_rsp_valid = pend;
  assign rd_rsp_data  = mem[paddr[9:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; paddr <= '0; pcnt <= '0;
      rd_req_ready <= 1'b0; out_ready <= 1'b0; cyc <= 0;
    end else begin
      cyc <= cyc + 1;
      rd_req_ready <= rq_stall ? cyc[0] : 1'b1;
      out_ready <= bp_mode ? ((cyc % 3) != 0) : 1'b1;
      if (rd_req_valid && rd_req_ready && !pend) begin
        pend <= 1'b1; paddr <= rd_req_addr; pcnt <= rd_req_beats;
      end else if (rd_rsp_valid && rd_rsp_ready) begin
        paddr <= paddr + 32'd4;
        pcnt <= pcnt - 1'b1;
        if (pcnt == 1) pend <= 1'b0;
      end
    end
  end

  logic [31:0] got_d [0:63]; logic [2:0] got_b [0:63]; bit got_l [0:63];
  logic [31:0] exp_d [0:63]; logic [2:0] exp_b [0:63]; bit exp_l [0:63];
  int got_n, exp_n, done_n, err_n, bad_fetch, bad_burst, hold_viol;
  int ncyc = 0, last_cyc, done_cyc;
  logic [31:0] bad_addr = 32'hFFFF_FFF0;
  bit pv = 0, pr = 0; logic [31:0] pd = '0;

  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (got_n < 64) begin
          got_d[got_n] = out_data; got_b[got_n] = out_bytes; got_l[got_n] = out_last;
        end
        got_n++; last_cyc = ncyc;
      end
      if (src_done) begin done_n++; done_cyc = ncyc; end
      if (desc_err) err_n++;
      if (rd_req_valid && rd_req_ready) begin
        if (rd_req_addr == bad_addr) bad_fetch++;
        if (rd_req_addr >= 32'h300 && rd_req_beats != 4) bad_burst++;
        if (rd_req_addr < 32'h300 && (rd_req_beats == 0 || rd_req_beats > MAXB)) bad_burst++;
      end
      if (pv && !pr && !(out_valid && out_data == pd)) hold_viol++;
      pv = out_valid; pr = out_ready; pd = out_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_job();
    got_n = 0; exp_n = 0; done_n = 0; err_n = 0;
    bad_fetch = 0; bad_burst = 0; hold_viol = 0;
    last_cyc = -100; done_cyc = -1;
  endtask

  task automatic add_seg(input int a, input int len, input bit fin);
    int nw = (len + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      exp_d[exp_n] = mem[(a >> 2) + k];
      exp_b[exp_n] = (k == nw - 1 && (len % 4) != 0) ? 3'(len % 4) : 3'd4;
      exp_l[exp_n] = fin && (k == nw - 1);
      exp_n++;
    end
  endtask

  task automatic put_desc(input int at, input int src, input int len, input int nxt, input bit term);
    mem[at >> 2]       = src;
    mem[(at >> 2) + 1] = len;
    mem[(at >> 2) + 2] = nxt;
    mem[(at >> 2) + 3] = {term, 31'h0};
  endtask

  task automatic launch(input bit lk, input int ptr, input int a, input int len);
    @(negedge clk);
    linked_mode = lk; first_desc_ptr = ptr; direct_addr = a; direct_len = len; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int t = 0;
    while (done_n == 0 && err_n == 0 && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) chk(0, "watchdog job timeout", t, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_job(input string tag, input int xdone, input int xerr);
    chk(got_n == exp_n, {tag, " word count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_d[i] == exp_d[i], {tag, " data"}, got_d[i], exp_d[i]);
      chk(got_b[i] == exp_b[i], {tag, " R6 byte qualifier"}, got_b[i], exp_b[i]);
      chk(got_l[i] == exp_l[i], {tag, " R7 last flag"}, got_l[i], exp_l[i]);
    end
    chk(done_n == xdone, {tag, " R8 done pulses"}, done_n, xdone);
    chk(err_n == xerr, {tag, " R9 error pulses"}, err_n, xerr);
    chk(busy == 1'b0, {tag, " R8 busy after end"}, busy, 0);
    chk(bad_burst == 0, {tag, " R3 R4 request beats"}, bad_burst, 0);
    chk(hold_viol == 0, {tag, " R10 output hold"}, hold_viol, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !rd_req_valid && !out_valid && !src_done && !desc_err,
        "R1 reset idle", {busy, rd_req_valid, out_valid, src_done, desc_err}, 0);
  endtask

  task automatic t_direct();
    clear_job(); bp_mode = 0; rq_stall = 0;
    add_seg(32'h40, 37, 1);
    launch(0, 0, 32'h40, 37);
    wait_end();
    cmp_job("R2 direct 37 bytes", 1, 0);
    chk(done_cyc - last_cyc == 2, "R8 done timing", done_cyc - last_cyc, 2);
  endtask

  task automatic t_direct_bp();
    clear_job(); bp_mode = 1; rq_stall = 1;
    add_seg(32'h80, 64, 1);
    launch(0, 0, 32'h80, 64);
    wait_end();
    cmp_job("R10 R3 direct backpressure", 1, 0);
    chk(done_cyc - last_cyc == 2, "R8 done timing bp", done_cyc - last_cyc, 2);
  endtask

  task automatic t_chain();
    clear_job(); bp_mode = 1; rq_stall = 1;
    put_desc(32'h300, 32'h100, 8, 32'h340, 0);
    put_desc(32'h340, 32'h200, 13, 32'h320, 0);
    put_desc(32'h320, 32'h180, 22, 32'h000, 1);
    add_seg(32'h100, 8, 0); add_seg(32'h200, 13, 0); add_seg(32'h180, 22, 1);
    launch(1, 32'h300, 0, 0);
    wait_end();
    cmp_job("R4 R5 three-link chain", 1, 0);
  endtask

  task automatic t_terminate();
    clear_job(); bp_mode = 0; rq_stall = 0; bad_addr = 32'h370;
    put_desc(32'h360, 32'h20, 3, 32'h370, 1);
    add_seg(32'h20, 3, 1);
    launch(1, 32'h360, 0, 0);
    wait_end();
    cmp_job("R5 terminate one link", 1, 0);
    chk(bad_fetch == 0, "R5 next not fetched after terminate", bad_fetch, 0);
  endtask

  task automatic t_bad_first();
    clear_job(); bad_addr = 32'h324;
    launch(1, 32'h324, 0, 0);
    wait_end();
    cmp_job("R9 misaligned first", 0, 1);
    chk(bad_fetch == 0, "R9 misaligned first not fetched", bad_fetch, 0);
  endtask

  task automatic t_bad_next();
    clear_job(); bp_mode = 1; bad_addr = 32'h348;
    put_desc(32'h380, 32'h60, 8, 32'h348, 0);
    add_seg(32'h60, 8, 0);
    launch(1, 32'h380, 0, 0);
    wait_end();
    cmp_job("R9 misaligned next", 0, 1);
    chk(bad_fetch == 0, "R9 misaligned next not fetched", bad_fetch, 0);
  endtask

  task automatic t_zero();
    clear_job(); bp_mode = 0;
    launch(0, 0, 32'h10, 0);
    wait_end();
    cmp_job("R12 zero length direct", 1, 0);
  endtask

  task automatic t_start_busy();
    clear_job(); bp_mode = 1; bad_addr = 32'h3C0;
    add_seg(32'h40, 24, 1);
    launch(0, 0, 32'h40, 24);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R11 busy during job", busy, 1);
    launch(1, 32'h3C0, 32'h0, 4);
    wait_end();
    cmp_job("R11 start while busy", 1, 0);
    chk(bad_fetch == 0, "R11 second start not acted on", bad_fetch, 0);
  endtask

  bit finished = 0;
  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'h5A, 8'(i), 16'(i * 7 + 3)};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_direct();
    t_direct_bp();
    t_chain();
    t_terminate();
    t_bad_first();
    t_bad_next();
    t_zero();
    t_start_busy();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog global timeout", 0, 1);
    finish_run();
  end
endmodule